// File: doc/BRIEF.md
# Serial Memory Slave Engine (SPI Mode 0)

This block is the serial front end of a byte-wide memory. A host drives chip select, serial clock and data in, and the engine decodes an 8-bit command followed by a 16-bit address and data phases. Received bits are taken on rising serial clock edges and returned bits are launched on falling edges, most significant bit first. A pause input freezes a transfer mid-stream without losing its position.

The engine keeps no write-enable latch, no protection state and no write timer. It emits single-cycle strobes (enable set, enable clear, status write, page-write byte) to neighbouring blocks and takes back a busy flag and the status byte to return. The storage array is a synchronous RAM model inside the block. Its depth is 2^ADDR_W bytes (15 gives 32K x 8). Neighbours fill it through a plain write port. All serial inputs are oversampled by the system clock through two-flop synchronisers. The serial clock must run at no more than one quarter of the system clock rate.

Top module: `spi_mem_slave`

## Requirements
- R1: Commands are decoded with bit 3 ignored: 0x06 pulses wen_set, 0x04 pulses wen_clr, 0x05 reads status, 0x01 writes status, 0x03 reads the array, 0x02 writes a page; 0x0E, 0x0C and so on behave the same.
- R2: A transfer starts when spi_cs_n falls; while spi_cs_n is high the engine returns to command decode and spi_so_oe is low.
- R3: Any other command byte locks the engine: later bits produce no strobe and spi_so_oe stays low until spi_cs_n rises and falls again.
- R4: After the read command, 16 address bits follow MSB first, and only the low ADDR_W bits are used. The first data bit is driven on the falling edge after the last address bit.
- R5: Read data streams while the clock runs; the address rises by one per byte and wraps from 2^ADDR_W-1 to 0.
- R6: spi_so_oe is low during the command and address bits.
- R7: With spi_hold_n low (taken while the serial clock is low), clock edges and data in are ignored and spi_so_oe is low. On release the transfer continues at the same bit.
- R8: While wr_busy is high when a command byte completes, every command other than status read is ignored.
- R9: A status read returns status_in and repeats it for every further byte.
- R10: The status write command pulses sr_wr with the 8 data bits on sr_data.
- R11: The page write command pulses pw_valid with pw_addr and pw_data per received byte. Only the low PAGE_W address bits count up, wrapping inside the page.
- R12: Each strobe lasts one system clock cycle.
- R13: A change of spi_hold_n while the serial clock is high is deferred until the clock is low; the clock edge in flight is still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_hold_n | input | 1 | Pause, active low |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so |
| wr_busy | input | 1 | Internal write cycle in progress |
| status_in | input | 8 | Status byte to return |
| wen_set | output | 1 | Write-enable set strobe |
| wen_clr | output | 1 | Write-enable clear strobe |
| sr_wr | output | 1 | Status write strobe |
| sr_data | output | 8 | Status write value |
| pw_valid | output | 1 | Page-write byte strobe |
| pw_addr | output | ADDR_W | Page-write byte address |
| pw_data | output | 8 | Page-write byte value |
| mem_we | input | 1 | Array write enable |
| mem_waddr | input | ADDR_W | Array write address |
| mem_wdata | input | 8 | Array write data |

## Verification
The pause input and a serial clock edge can land in the same system cycle. The block must then honour the edge and defer the pause until the clock is low. The bench provokes this by dropping spi_hold_n together with a rising clock edge inside the address phase, and by dropping it right after a falling edge in the data phase. It then toggles the clock with junk data while paused. It judges the result by the bytes read back, which must match the model array at the intended address, and by spi_so_oe staying low while paused.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_STIN,
        PH_RDOUT,
        PH_STOUT,
        PH_DONE,
        PH_LOCK
    } phase_e;

    localparam logic [7:0] CMD_MASK  = 8'hF7;
    localparam logic [7:0] CMD_WEN   = 8'h06;
    localparam logic [7:0] CMD_WDIS  = 8'h04;
    localparam logic [7:0] CMD_STRD  = 8'h05;
    localparam logic [7:0] CMD_STWR  = 8'h01;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_WRITE = 8'h02;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] sync_prev
);

    logic [W-1:0] stage_q [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i <= STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out  = stage_q[STAGES-1];
    assign sync_prev = stage_q[STAGES];

endmodule

// File: rtl/spi_mem_ram.sv
module spi_mem_ram #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_hold_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic              wr_busy,
    input  logic [7:0]        status_in,
    output logic              wen_set,
    output logic              wen_clr,
    output logic              sr_wr,
    output logic [7:0]        sr_data,
    output logic              pw_valid,
    output logic [ADDR_W-1:0] pw_addr,
    output logic [7:0]        pw_data,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [7:0]        mem_wdata
);

    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] SYNC_RST = 4'b0110;  // {si, hold_n, cs_n, sck}
    localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
    localparam logic [PAGE_W-1:0] PAGE_ONE = 1;

    typedef struct packed {
        phase_e            ph;
        logic              is_rd;
        logic [3:0]        cnt;
        logic [15:0]       sh;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        ocnt;
        logic [7:0]        obuf;
        logic              so;
        logic              drv;
        logic              held;
        logic              oe;
        logic              wen_set;
        logic              wen_clr;
        logic              sr_wr;
        logic              pw_valid;
        logic [7:0]        sr_data;
        logic [7:0]        pw_data;
        logic [ADDR_W-1:0] pw_addr;
    } state_t;

    state_t q, d;

    logic [NSIG-1:0] sig_s, sig_p;
    logic            sck_s, cs_s, hold_s, si_s;
    logic            rise, fall;
    logic [7:0]      ram_rdata;

    spi_mem_sync #(
        .W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_in({spi_si, spi_hold_n, spi_cs_n, spi_sck}),
        .sync_out(sig_s), .sync_prev(sig_p)
    );

    spi_mem_ram #(.AW(ADDR_W)) u_ram (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(q.addr), .rdata(ram_rdata)
    );

    assign sck_s  = sig_s[0];
    assign cs_s   = sig_s[1];
    assign hold_s = sig_s[2];
    assign si_s   = sig_s[3];
    assign rise   = sck_s & ~sig_p[0];
    assign fall   = ~sck_s & sig_p[0];

    always_comb begin
        logic [15:0] shin;
        logic [7:0]  cmd;
        logic [7:0]  src;
        d = q;
        d.wen_set  = 1'b0;
        d.wen_clr  = 1'b0;
        d.sr_wr    = 1'b0;
        d.pw_valid = 1'b0;
        shin = {q.sh[14:0], si_s};
        cmd  = shin[7:0] & CMD_MASK;
        src  = (q.ph == PH_RDOUT) ? ram_rdata : status_in;

        if (cs_s) begin
            d.ph   = PH_CMD;
            d.cnt  = '0;
            d.ocnt = '0;
            d.drv  = 1'b0;
            d.held = 1'b0;
        end else begin
            if (!sck_s) d.held = ~hold_s;
            if (!q.held && rise) begin
                case (q.ph)
                    PH_CMD: begin
                        d.sh  = shin;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            d.cnt = '0;
                            if (wr_busy && cmd != CMD_STRD) begin
                                d.ph = PH_DONE;
                            end else begin
                                case (cmd)
                                    CMD_WEN:   begin d.wen_set = 1'b1; d.ph = PH_DONE; end
                                    CMD_WDIS:  begin d.wen_clr = 1'b1; d.ph = PH_DONE; end
                                    CMD_STRD:  d.ph = PH_STOUT;
                                    CMD_STWR:  d.ph = PH_STIN;
                                    CMD_READ:  begin d.ph = PH_ADDR; d.is_rd = 1'b1; end
                                    CMD_WRITE: begin d.ph = PH_ADDR; d.is_rd = 1'b0; end
                                    default:   d.ph = PH_LOCK;
                                endcase
                            end
                        end
                    end
                    PH_ADDR: begin
                        d.sh  = shin;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd15) begin
                            d.cnt  = '0;
                            d.addr = shin[ADDR_W-1:0];
                            d.ph   = q.is_rd ? PH_RDOUT : PH_WDATA;
                        end
                    end
                    PH_WDATA, PH_STIN: begin
                        d.sh  = shin;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            d.cnt = '0;
                            if (q.ph == PH_STIN) begin
                                d.sr_wr   = 1'b1;
                                d.sr_data = shin[7:0];
                                d.ph      = PH_DONE;
                            end else begin
                                d.pw_valid = 1'b1;
                                d.pw_addr  = q.addr;
                                d.pw_data  = shin[7:0];
                                d.addr[PAGE_W-1:0] = q.addr[PAGE_W-1:0] + PAGE_ONE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (!q.held && fall && (q.ph == PH_RDOUT || q.ph == PH_STOUT)) begin
                d.drv = 1'b1;
                if (q.ocnt == 3'd0) begin
                    d.so   = src[7];
                    d.obuf = {src[6:0], 1'b0};
                    if (q.ph == PH_RDOUT) d.addr = q.addr + ADDR_ONE;
                end else begin
                    d.so   = q.obuf[7];
                    d.obuf = {q.obuf[6:0], 1'b0};
                end
                d.ocnt = q.ocnt + 3'd1;
            end
        end
        d.oe = ~cs_s & d.drv & ~d.held & (d.ph == PH_RDOUT || d.ph == PH_STOUT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ph: PH_CMD, default: '0};
        end else begin
            q <= d;
        end
    end

    assign spi_so    = q.so;
    assign spi_so_oe = q.oe;
    assign wen_set   = q.wen_set;
    assign wen_clr   = q.wen_clr;
    assign sr_wr     = q.sr_wr;
    assign sr_data   = q.sr_data;
    assign pw_valid  = q.pw_valid;
    assign pw_addr   = q.pw_addr;
    assign pw_data   = q.pw_data;

    // R2: deselect silences the output on the next cycle
    p_cs_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_so_oe);

    // R3: a locked transfer emits nothing
    p_lock_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_LOCK) |=> !(wen_set || wen_clr || sr_wr || pw_valid || spi_so_oe));

    // R7: paused engine never drives
    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.held |-> !spi_so_oe);

    // R8: enable strobe only when the engine was not busy at decode
    p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wen_set) |-> $past(!wr_busy));

    // R12: strobes last a single cycle
    p_pulse_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_valid || sr_wr || wen_set || wen_clr) |=> !(q.pw_valid && $past(q.pw_valid))
            && !(q.sr_wr && $past(q.sr_wr)));

endmodule

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;

    localparam int AW    = 10;
    localparam int PW    = 6;
    localparam int DEPTH = 1 << AW;
    localparam int HP    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
    logic so, so_oe;
    logic busy = 1'b0;
    logic [7:0] status = 8'h00;
    logic ws, wc, srw, pwv;
    logic [7:0] srd, pwd;
    logic [AW-1:0] pwa;
    logic mwe = 1'b0;
    logic [AW-1:0] mwa = '0;
    logic [7:0] mwd = '0;

    int checks = 0, errors = 0;
    int n_ws = 0, n_wc = 0, n_sr = 0, n_pw = 0;
    logic [7:0] last_sr = 8'h00;
    logic [AW-1:0] log_a [256];
    logic [7:0] log_d [256];
    logic [7:0] exp_mem [DEPTH];
    bit finished = 0;

    always #10 clk = ~clk;

    spi_mem_slave #(.ADDR_W(AW), .PAGE_W(PW)) u_spi_mem_slave (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_hold_n(hold_n), .spi_si(si), .spi_so(so), .spi_so_oe(so_oe),
        .wr_busy(busy), .status_in(status), .wen_set(ws), .wen_clr(wc),
        .sr_wr(srw), .sr_data(srd), .pw_valid(pwv), .pw_addr(pwa),
        .pw_data(pwd), .mem_we(mwe), .mem_waddr(mwa), .mem_wdata(mwd)
    );

    always @(negedge clk) begin
        if (ws) n_ws++;
        if (wc) n_wc++;
        if (srw) begin n_sr++; last_sr = srd; end
        if (pwv) begin log_a[n_pw[7:0]] = pwa; log_d[n_pw[7:0]] = pwd; n_pw++; end
    end

    function automatic logic [7:0] exp_rd(input logic [15:0] a, input int i);
        return exp_mem[(int'(a) + i) & (DEPTH - 1)];
    endfunction

    function automatic logic [AW-1:0] exp_pw(input logic [15:0] a, input int i);
        logic [AW-1:0] b;
        b = a[AW-1:0];
        b[PW-1:0] = b[PW-1:0] + PW'(i);
        return b;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_x(input logic b, output logic s, output logic o);
        si = b;
        wait_clk(HP);
        s = so; o = so_oe;
        sck = 1'b1;
        wait_clk(HP);
        sck = 1'b0;
    endtask

    task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx,
                          output logic oe_any, output logic oe_all);
        logic s, o;
        rx = '0; oe_any = 1'b0; oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            bit_x(tx[i], s, o);
            rx = {rx[6:0], s};
            oe_any |= o; oe_all &= o;
        end
    endtask

    task automatic sel;   cs_n = 1'b0; wait_clk(HP); endtask
    task automatic desel; wait_clk(HP); cs_n = 1'b1; wait_clk(3 * HP); endtask

    task automatic cmd_only(input logic [7:0] c);
        logic [7:0] r; logic oa, ol;
        sel; byte_x(c, r, oa, ol); desel;
    endtask

    task automatic do_read(input logic [7:0] c, input logic [15:0] a, input int len, input string req);
        logic [7:0] r; logic oa, ol, any_hdr;
        sel;
        byte_x(c, r, oa, ol); any_hdr = oa;
        byte_x(a[15:8], r, oa, ol); any_hdr |= oa;
        byte_x(a[7:0], r, oa, ol); any_hdr |= oa;
        check("R6 oe low in header", int'(any_hdr), 0);
        for (int i = 0; i < len; i++) begin
            byte_x(8'h00, r, oa, ol);
            check({req, " read byte"}, r, exp_rd(a, i));
            check("R4 oe during data", int'(ol), 1);
        end
        desel;
    endtask

    task automatic do_write(input logic [15:0] a, input int len);
        logic [7:0] r, v; logic oa, ol;
        int base;
        base = n_pw;
        sel;
        byte_x(8'h02, r, oa, ol);
        byte_x(a[15:8], r, oa, ol);
        byte_x(a[7:0], r, oa, ol);
        for (int i = 0; i < len; i++) begin
            v = 8'($urandom);
            byte_x(v, r, oa, ol);
            wait_clk(4);
            check("R11 pw count", n_pw - base, i + 1);
            check("R11 pw addr", log_a[(base + i) & 255], exp_pw(a, i));
            check("R11 pw data", log_d[(base + i) & 255], v);
        end
        desel;
    endtask

    initial begin
        int k;
        logic [7:0] r, st; logic oa, ol, s, o, junk;
        logic [15:0] a;
        k = $urandom(32'd20240611);
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        check("R2 reset oe", int'(so_oe), 0);
        check("R12 reset strobes", int'({ws, wc, srw, pwv}), 0);

        for (int i = 0; i < DEPTH; i++) begin
            mwe = 1'b1; mwa = AW'(i); mwd = 8'($urandom); exp_mem[i] = mwd;
            wait_clk(1);
        end
        mwe = 1'b0;

        cmd_only(8'h06); check("R1 wen_set 0x06", n_ws, 1);
        cmd_only(8'h0E); check("R1 wen_set 0x0E", n_ws, 2);
        cmd_only(8'h04); check("R1 wen_clr 0x04", n_wc, 1);
        cmd_only(8'h0C); check("R1 wen_clr 0x0C", n_wc, 2);
        check("R12 one pulse per command", n_ws + n_wc, 4);

        for (int t = 0; t < 2; t++) begin
            status = 8'($urandom);
            sel;
            byte_x(t == 0 ? 8'h05 : 8'h0D, r, oa, ol);
            check("R6 oe low during status cmd", int'(oa), 0);
            for (int i = 0; i < 3; i++) begin
                byte_x(8'h00, r, oa, ol);
                check("R9 status repeat", r, status);
            end
            desel;
        end

        for (int t = 0; t < 6; t++) begin
            a = 16'($urandom);
            do_read(t[0] ? 8'h0B : 8'h03, a, 1 + t % 4, "R4");
        end
        do_read(8'h03, 16'hFFFE, 4, "R5 wrap");
        do_read(8'h03, 16'(DEPTH - 1), 2, "R5 top");

        do_write(16'h0000 | 16'(62), 4);
        do_write(16'h8000 | 16'(5 * 64 + 61), 5);
        for (int t = 0; t < 3; t++) do_write(16'($urandom), 2);

        st = 8'($urandom);
        sel; byte_x(8'h01, r, oa, ol); byte_x(st, r, oa, ol); wait_clk(4);
        check("R10 sr_wr count", n_sr, 1);
        check("R10 sr_data", last_sr, st);
        desel;

        k = n_ws;
        sel; byte_x(8'h07, r, oa, ol); byte_x(8'h06, r, oa, ol);
        byte_x(8'h05, r, oa, ol);
        check("R3 locked oe", int'(oa), 0);
        desel;
        check("R3 locked no strobe", n_ws, k);
        cmd_only(8'h06);
        check("R3 unlock after reselect", n_ws, k + 1);

        busy = 1'b1;
        k = n_ws;
        cmd_only(8'h06);
        check("R8 busy blocks enable", n_ws, k);
        k = n_pw;
        sel; byte_x(8'h02, r, oa, ol); byte_x(8'h00, r, oa, ol);
        byte_x(8'h10, r, oa, ol); byte_x(8'hA5, r, oa, ol); desel;
        check("R8 busy blocks write", n_pw, k);
        status = 8'hFF;
        sel; byte_x(8'h05, r, oa, ol); byte_x(8'h00, r, oa, ol);
        check("R8 status read while busy", r, 8'hFF);
        desel;
        busy = 1'b0;

        // R7: pause in the address phase and in the data phase
        a = 16'($urandom);
        sel;
        byte_x(8'h03, r, oa, ol);
        byte_x(a[15:8], r, oa, ol);
        for (int i = 7; i >= 4; i--) bit_x(a[i], s, o);
        hold_n = 1'b0;
        wait_clk(HP);
        for (int j = 0; j < 2; j++) begin
            si = ~si; sck = 1'b1; wait_clk(HP); sck = 1'b0; wait_clk(HP);
        end
        hold_n = 1'b1;
        for (int i = 3; i >= 0; i--) bit_x(a[i], s, o);
        r = '0;
        for (int i = 0; i < 3; i++) begin bit_x(1'b0, s, o); r = {r[6:0], s}; end
        hold_n = 1'b0;
        wait_clk(2 * HP);
        check("R7 oe low while paused", int'(so_oe), 0);
        for (int j = 0; j < 3; j++) begin
            sck = 1'b1; wait_clk(HP); sck = 1'b0; wait_clk(HP);
        end
        check("R7 oe low after paused clocks", int'(so_oe), 0);
        hold_n = 1'b1;
        for (int i = 0; i < 5; i++) begin bit_x(1'b0, s, o); r = {r[6:0], s}; end
        check("R7 byte across pause", r, exp_rd(a, 0));
        byte_x(8'h00, r, oa, ol);
        check("R7 next byte after pause", r, exp_rd(a, 1));
        desel;

        // R13: pause lands together with a rising clock edge
        a = 16'($urandom);
        sel;
        byte_x(8'h03, r, oa, ol);
        for (int i = 15; i >= 5; i--) bit_x(a[i], s, o);
        si = a[4];
        wait_clk(HP);
        sck = 1'b1; hold_n = 1'b0;
        wait_clk(HP);
        sck = 1'b0;
        wait_clk(HP);
        for (int j = 0; j < 2; j++) begin
            junk = 1'($urandom); si = junk;
            sck = 1'b1; wait_clk(HP); sck = 1'b0; wait_clk(HP);
        end
        check("R13 oe low while paused", int'(so_oe), 0);
        hold_n = 1'b1;
        for (int i = 3; i >= 0; i--) bit_x(a[i], s, o);
        byte_x(8'h00, r, oa, ol);
        check("R13 edge with pause honoured", r, exp_rd(a, 0));
        desel;
        check("R2 oe low when deselected", int'(so_oe), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule